// File: doc/BRIEF.md
# Serial Command and Decay-Table Receiver

This block takes 16-bit serial words for one pair of motor phases and turns them into the settings a downstream chopper needs. A data line is captured on the falling edge of a serial clock and shifted on its rising edge, least significant bit first. A rising edge on a latch strobe copies the finished word into one of two registers. A mode pin chooses the register.

With the mode pin low, the word becomes the command register. It holds a shared two-bit torque code and, for each phase, a decay selector, a four-bit current code and a polarity bit. With the mode pin high, the word becomes a four-entry mixed-decay timing table instead. Each entry holds a slow/mixed flag and a three-bit ratio.

The two registers are cleared by different sources. The command register is zeroed by an internal protection reset, and a zero current code means the outputs are off. The table goes back to its defaults only on the power-on reset of the block. All serial inputs are synchronised to a fast system clock and edge-detected. Each serial clock phase must therefore last at least three system clocks.

Top module: `ser_cmd_if`

## Requirements
- R1: Words are 16 bits long. The first bit shifted in ends up at bit 0 and the sixteenth at bit 15. Data is captured when the serial clock falls and shifted when it rises.
- R2: Only a rising edge of the strobe updates a register. A strobe held high or falling while bits are shifted leaves both registers unchanged.
- R3: When the strobe rises with the mode pin low, the command register loads the word with this layout: bits 1:0 torque, bits 3:2 phase-B decay, bits 7:4 phase-B current, bit 8 phase-B polarity, bits 10:9 phase-A decay, bits 14:11 phase-A current, bit 15 phase-A polarity.
- R4: When the strobe rises with the mode pin high, the table loads the word and the command register is unchanged. Entry k sits in bits 4k+3..4k, with the mixed flag at bit 4k+3 and the ratio at bits 4k+2..4k.
- R5: After power-on reset, the command register is all zero and the table word is 16'hFDA0. That is entry 0 slow, ratio 000; entry 1 mixed, ratio 010; entry 2 mixed, ratio 101; entry 3 mixed, ratio 111.
- R6: While the unit reset input is low, the shift register is held at zero. A word shifted before such a pulse and strobed after it loads as zero.
- R7: A strobe is ignored, and both registers are kept, while the unit reset input is low or the protection reset is high.
- R8: The protection reset zeroes the command register one system clock after it is sampled high, and holds it at zero while it stays high. The table is not affected.
- R9: The table keeps its contents across mode-pin changes and command writes. Only power-on reset restores the defaults.
- R10: A register changes on the third system-clock rising edge after the strobe input rises, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock |
| ser_strobe | input | 1 | Latch strobe, acts on rising edge |
| mode_table | input | 1 | 0 selects command register, 1 selects decay table |
| unit_rst_n | input | 1 | Unit reset, active low, clears the shift register |
| prot_rst | input | 1 | Internal protection reset, active high, synchronous |
| torque | output | 2 | Shared torque code |
| dec_a | output | 2 | Phase-A decay selector |
| cur_a | output | 4 | Phase-A current code |
| pol_a | output | 1 | Phase-A polarity |
| dec_b | output | 2 | Phase-B decay selector |
| cur_b | output | 4 | Phase-B current code |
| pol_b | output | 1 | Phase-B polarity |
| tbl_mixed | output | 4 | Mixed flag of each table entry, bit k for entry k |
| tbl_ratio | output | 12 | Ratio of each entry, bits 3k+2..3k for entry k |

## Verification
The bench uses single-bit words at each end of the word to confirm bit order. If the order were reversed, phase-A polarity would appear in the torque field. It holds the strobe high through a whole shift to catch a design that latches on level rather than on edge, which would copy a half-shifted word.

Words are strobed during a unit-reset pulse and during a protection reset. A design that loaded anyway would overwrite the table or revive an outputs-off command. The bench also shifts a word, pulses the unit reset, and only then strobes, which exposes a shift register that is not cleared.

Table retention is checked across mode changes and command writes, and the defaults are checked after a later power-on reset. A design that cleared the table on the wrong reset fails these checks. The output is sampled both two and four system clocks after a strobe, so a latency that is one cycle short or long is reported.

// File: rtl/ser_cmd_pkg.sv
package ser_cmd_pkg;
  localparam int WORD_W  = 16;
  localparam int ENTRIES = 4;
  localparam int RATIO_W = 3;
  localparam int ENTRY_W = RATIO_W + 1;
  localparam logic [WORD_W-1:0] TBL_DEFAULT = 16'hFDA0;

  // command word, most significant field first
  typedef struct packed {
    logic       pol_a;
    logic [3:0] cur_a;
    logic [1:0] dec_a;
    logic       pol_b;
    logic [3:0] cur_b;
    logic [1:0] dec_b;
    logic [1:0] torque;
  } cmd_t;

  typedef struct packed {
    logic               mixed;
    logic [RATIO_W-1:0] ratio;
  } tbl_entry_t;

  typedef tbl_entry_t [ENTRIES-1:0] tbl_t;
endpackage

// File: rtl/sc_sync_edge.sv
module sc_sync_edge #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] pipe_q, pipe_d;
  logic [W-1:0]             prev_q, prev_d;

  always_comb begin
    pipe_d[0] = d_in;
    for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
    prev_d = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      prev_q <= '0;
    end else begin
      pipe_q <= pipe_d;
      prev_q <= prev_d;
    end
  end

  assign lvl  = pipe_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/sc_shift.sv
module sc_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         smp,
  input  logic         adv,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  logic         hold_q, hold_d;
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    hold_d = hold_q;
    sr_d   = sr_q;
    if (clr) begin
      hold_d = 1'b0;
      sr_d   = '0;
    end else begin
      if (smp) hold_d = bit_in;
      if (adv) sr_d = {hold_q, sr_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      sr_q   <= '0;
    end else begin
      hold_q <= hold_d;
      sr_q   <= sr_d;
    end
  end

  assign word = sr_q;
endmodule

// File: rtl/sc_word_latch.sv
module sc_word_latch #(
  parameter int           W    = 16,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] word_out
);
  logic [W-1:0] q, d;

  always_comb begin
    d = q;
    if (clear)     d = '0;
    else if (load) d = word_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= INIT;
    else        q <= d;
  end

  assign word_out = q;
endmodule

// File: rtl/ser_cmd_if.sv
module ser_cmd_if
  import ser_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        sys_clk,
  input  logic        sys_rst_n,
  input  logic        ser_data,
  input  logic        ser_clk,
  input  logic        ser_strobe,
  input  logic        mode_table,
  input  logic        unit_rst_n,
  input  logic        prot_rst,
  output logic [1:0]  torque,
  output logic [1:0]  dec_a,
  output logic [3:0]  cur_a,
  output logic        pol_a,
  output logic [1:0]  dec_b,
  output logic [3:0]  cur_b,
  output logic        pol_b,
  output logic [ENTRIES-1:0]         tbl_mixed,
  output logic [ENTRIES*RATIO_W-1:0] tbl_ratio
);
  localparam int NSIG = 5;
  localparam int I_DAT = 0, I_CLK = 1, I_STB = 2, I_MOD = 3, I_URS = 4;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n;
  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) rst_pipe <= 2'b00;
    else            rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  logic [NSIG-1:0] in_raw, in_lvl, in_rise, in_fall;
  assign in_raw = {unit_rst_n, mode_table, ser_strobe, ser_clk, ser_data};

  sc_sync_edge #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk (sys_clk), .rst_n (rst_n), .d_in (in_raw),
    .lvl (in_lvl), .rise (in_rise), .fall (in_fall)
  );

  logic stb_rise, mode_s, urst_s, wr_ok, cmd_load, tbl_load;
  assign stb_rise = in_rise[I_STB];
  assign mode_s   = in_lvl[I_MOD];
  assign urst_s   = in_lvl[I_URS];
  assign wr_ok    = urst_s & ~prot_rst;
  assign cmd_load = stb_rise & ~mode_s & wr_ok;
  assign tbl_load = stb_rise &  mode_s & wr_ok;

  logic [WORD_W-1:0] shreg;
  sc_shift #(.W(WORD_W)) u_shift (
    .clk (sys_clk), .rst_n (rst_n), .clr (~urst_s),
    .smp (in_fall[I_CLK]), .adv (in_rise[I_CLK]),
    .bit_in (in_lvl[I_DAT]), .word (shreg)
  );

  logic [WORD_W-1:0] cmd_word, tbl_word;
  sc_word_latch #(.W(WORD_W), .INIT('0)) u_cmd (
    .clk (sys_clk), .rst_n (rst_n), .clear (prot_rst), .load (cmd_load),
    .word_in (shreg), .word_out (cmd_word)
  );
  sc_word_latch #(.W(WORD_W), .INIT(TBL_DEFAULT)) u_tbl (
    .clk (sys_clk), .rst_n (rst_n), .clear (1'b0), .load (tbl_load),
    .word_in (shreg), .word_out (tbl_word)
  );

  cmd_t cmd_q;
  tbl_t tbl_q;
  assign cmd_q = cmd_t'(cmd_word);
  assign tbl_q = tbl_t'(tbl_word);

  assign torque = cmd_q.torque;
  assign dec_a  = cmd_q.dec_a;
  assign cur_a  = cmd_q.cur_a;
  assign pol_a  = cmd_q.pol_a;
  assign dec_b  = cmd_q.dec_b;
  assign cur_b  = cmd_q.cur_b;
  assign pol_b  = cmd_q.pol_b;

  for (genvar k = 0; k < ENTRIES; k++) begin : g_tbl
    assign tbl_mixed[k]                   = tbl_q[k].mixed;
    assign tbl_ratio[k*RATIO_W +: RATIO_W] = tbl_q[k].ratio;
  end
endmodule

// File: rtl/ser_cmd_if_chk.sv
module ser_cmd_if_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        prot_rst,
  input logic        stb_rise,
  input logic        mode_s,
  input logic        urst_s,
  input logic [15:0] shreg,
  input logic [15:0] cmd_w,
  input logic [15:0] tbl_w
);
  a_r8_prot_clears_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    prot_rst |=> (cmd_w == 16'h0000));
  a_r6_unit_rst_clears_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !urst_s |=> (shreg == 16'h0000));
  a_r7_table_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (!urst_s || prot_rst) |=> $stable(tbl_w));
  a_r4_cmd_kept_in_table_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && !prot_rst) |=> $stable(cmd_w));
  a_r2_cmd_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_rise && !prot_rst) |=> $stable(cmd_w));
  a_r9_table_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_rise && mode_s) |=> $stable(tbl_w));
endmodule

bind ser_cmd_if ser_cmd_if_chk i_chk (
  .clk (sys_clk), .rst_n (rst_n), .prot_rst (prot_rst), .stb_rise (stb_rise),
  .mode_s (mode_s), .urst_s (urst_s), .shreg (shreg),
  .cmd_w (cmd_word), .tbl_w (tbl_word)
);

// File: tb/test_ser_cmd_if.sv
module test_ser_cmd_if;
  logic clk = 1'b0;
  logic sys_rst_n, ser_data, ser_clk, ser_strobe, mode_table, unit_rst_n, prot_rst;
  logic [1:0] torque, dec_a, dec_b;
  logic [3:0] cur_a, cur_b, tbl_mixed;
  logic pol_a, pol_b;
  logic [11:0] tbl_ratio;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  localparam logic [15:0] TBL_DEF = 16'hFDA0;
  logic [15:0] exp_cmd, exp_tbl;

  always #10 clk = ~clk;

  ser_cmd_if i_ser_cmd_if (
    .sys_clk(clk), .sys_rst_n(sys_rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_strobe(ser_strobe), .mode_table(mode_table), .unit_rst_n(unit_rst_n),
    .prot_rst(prot_rst), .torque(torque), .dec_a(dec_a), .cur_a(cur_a), .pol_a(pol_a),
    .dec_b(dec_b), .cur_b(cur_b), .pol_b(pol_b), .tbl_mixed(tbl_mixed), .tbl_ratio(tbl_ratio)
  );

  // reassemble outputs per the layouts of R3 and R4
  function automatic logic [15:0] cmd_now();
    return {pol_a, cur_a, dec_a, pol_b, cur_b, dec_b, torque};
  endfunction
  function automatic logic [15:0] tbl_now();
    logic [15:0] w;
    for (int k = 0; k < 4; k++) w[4*k +: 4] = {tbl_mixed[k], tbl_ratio[3*k +: 3]};
    return w;
  endfunction
  function automatic logic [3:0] exp_cur_a(input logic [15:0] w); return w[14:11]; endfunction
  function automatic logic [3:0] exp_cur_b(input logic [15:0] w); return w[7:4]; endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_word(input logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      ser_data = w[i];
      ser_clk  = 1'b0;
      step(4);
      ser_clk  = 1'b1;
      step(4);
    end
  endtask

  task automatic pulse_strobe();
    ser_strobe = 1'b1;
    step(4);
    ser_strobe = 1'b0;
    step(4);
  endtask

  task automatic write_cmd(input logic [15:0] w);
    mode_table = 1'b0; shift_word(w); pulse_strobe();
  endtask
  task automatic write_tbl(input logic [15:0] w);
    mode_table = 1'b1; shift_word(w); pulse_strobe(); mode_table = 1'b0;
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] w, w2;
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    sys_rst_n = 1'b0; ser_data = 1'b0; ser_clk = 1'b1; ser_strobe = 1'b0;
    mode_table = 1'b0; unit_rst_n = 1'b1; prot_rst = 1'b0;
    step(5);
    sys_rst_n = 1'b1;
    step(8);

    // R5 reset state
    check("R5 cmd", cmd_now(), 16'h0000);
    check("R5 tbl", tbl_now(), TBL_DEF);
    check("R5 cur_a", cur_a, 4'h0);
    exp_tbl = TBL_DEF;

    // R1 bit order at both ends
    write_cmd(16'h0001);
    check("R1 bit0 torque", {pol_a, torque}, 3'b001);
    write_cmd(16'h8000);
    check("R1 bit15 pol_a", {pol_a, torque}, 3'b100);

    // R3 random command words
    for (int i = 0; i < 16; i++) begin
      w = 16'($urandom);
      write_cmd(w);
      exp_cmd = w;
      check("R3 cmd", cmd_now(), exp_cmd);
      check("R3 cur_a", cur_a, exp_cur_a(w));
      check("R3 cur_b", cur_b, exp_cur_b(w));
      check("R9 tbl kept", tbl_now(), exp_tbl);
    end

    // R4 random table words
    for (int i = 0; i < 6; i++) begin
      w = 16'($urandom);
      write_tbl(w);
      exp_tbl = w;
      check("R4 tbl", tbl_now(), exp_tbl);
      check("R4 cmd kept", cmd_now(), exp_cmd);
    end

    // R10 latency and R2 edge-only latching with strobe held high
    w = 16'h3C5A; w2 = 16'hA5C3;
    mode_table = 1'b0; shift_word(w);
    ser_strobe = 1'b1;
    step(2);
    check("R10 not before", cmd_now(), exp_cmd);
    step(2);
    check("R10 at edge", cmd_now(), w);
    exp_cmd = w;
    shift_word(w2);
    check("R2 held high", cmd_now(), exp_cmd);
    ser_strobe = 1'b0; step(6);
    check("R2 falling", cmd_now(), exp_cmd);
    pulse_strobe();
    exp_cmd = w2;
    check("R2 rise", cmd_now(), exp_cmd);

    // R6 unit reset clears shift register
    shift_word(16'hFFFF);
    unit_rst_n = 1'b0; step(6); unit_rst_n = 1'b1; step(6);
    pulse_strobe();
    exp_cmd = 16'h0000;
    check("R6 cleared word", cmd_now(), exp_cmd);

    // R7 strobe ignored while unit reset low
    write_cmd(16'h1234); exp_cmd = 16'h1234;
    mode_table = 1'b1; shift_word(16'h0F0F);
    unit_rst_n = 1'b0; step(4);
    pulse_strobe();
    check("R7 tbl urst", tbl_now(), exp_tbl);
    mode_table = 1'b0; pulse_strobe();
    check("R7 cmd urst", cmd_now(), exp_cmd);
    unit_rst_n = 1'b1; step(6);

    // R8 protection reset
    prot_rst = 1'b1; step(1);
    check("R8 cleared", cmd_now(), 16'h0000);
    check("R8 off a", cur_a, 4'h0);
    check("R8 off b", cur_b, 4'h0);
    exp_cmd = 16'h0000;
    write_cmd(16'h7777);
    check("R8 held", cmd_now(), exp_cmd);
    mode_table = 1'b1; pulse_strobe(); mode_table = 1'b0;
    check("R7 tbl prot", tbl_now(), exp_tbl);
    prot_rst = 1'b0; step(2);
    check("R8 tbl intact", tbl_now(), exp_tbl);
    pulse_strobe();
    exp_cmd = 16'h7777;
    check("R8 writes resume", cmd_now(), exp_cmd);

    // R9 retention across mode changes, then power-on defaults
    write_tbl(16'h4E21); exp_tbl = 16'h4E21;
    for (int i = 0; i < 3; i++) begin
      mode_table = 1'b1; step(6); mode_table = 1'b0; step(6);
      w = 16'($urandom);
      write_cmd(w);
    end
    check("R9 tbl retained", tbl_now(), exp_tbl);
    sys_rst_n = 1'b0; step(3); sys_rst_n = 1'b1; step(6);
    check("R9 tbl default", tbl_now(), TBL_DEF);
    check("R5 cmd after por", cmd_now(), 16'h0000);

    done = 1'b1;
    report();
    $finish;
  end
endmodule